// File: doc/BRIEF.md
# ADC Queue Status Flag Register

This block keeps the sticky status flags of a two-queue analog-to-digital conversion sequencer. It watches the completion strobe for queue 1 and works out whether the command word just converted was the last one of that queue. If it was, it sets a completion flag. Five more flags record queue 2 completion, a pause on either queue and a trigger overrun on either queue. Each of these is set by its own one-cycle input strobe.

Software reads the flags as one 16-bit status word. The remaining ten bits of that word come from an input and are read-only. Software can clear a flag only by writing zero to it after a read has returned that flag as one. A hidden arm bit per flag remembers that qualifying read. While the queue 1 completion flag is set and its interrupt is enabled, the block raises an interrupt request and presents the programmed request level.

Top module: `adc_qstat_reg`

## Requirements
- R1: After reset every flag is zero. The status word places the queue 1 completion flag at bit 15, the queue 1 pause flag at bit 14, the queue 2 completion flag at bit 13, the queue 2 pause flag at bit 12, the queue 1 trigger-overrun flag at bit 11 and the queue 2 trigger-overrun flag at bit 10. Bits 9:0 mirror `ro_fields`.
- R2: Writes never change bits 9:0 of the status word.
- R3: A flag clears only on a write with a zero in its bit position, and only when an earlier read returned that bit as one. A zero write without such a read leaves the flag at one.
- R4: Any write consumes every arm bit. A write of one leaves the flag set, and a later zero write then has no effect until a new read returns the flag as one.
- R5: The queue 1 completion flag is set one cycle after `q1_cw_done` when `cw_idx + 1` equals `q2_begin`. A `q2_begin` of 0 never matches.
- R6: The queue 1 completion flag is set on `q1_cw_done` when `cw_chan` equals the end-of-queue code 63.
- R7: The queue 1 completion flag is set on `q1_cw_done` when `cw_idx` is 63, the last command-memory location.
- R8: A `q1_cw_done` that meets none of the end conditions of R5 to R7 does not set the queue 1 completion flag.
- R9: The queue 1 completion flag is set whether or not `cf1_irq_en` is high. `irq_req` equals that flag ANDed with `cf1_irq_en`. `irq_level` equals `cf1_irq_lvl` while `irq_req` is high and zero otherwise.
- R10: Once set, the queue 1 completion flag stays set until the clear sequence of R3 or a reset.
- R11: When a set strobe and a valid clearing write hit the same flag in one cycle, the flag stays one.
- R12: Each of `pf1_set`, `cf2_set`, `pf2_set`, `tor1_set` and `tor2_set` sets its own flag one cycle later and touches no other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q1_cw_done | input | 1 | Queue 1 command word converted and stored |
| cw_idx | input | 6 | Command-memory index of the completed word |
| cw_chan | input | 6 | Channel code of the completed word |
| q2_begin | input | 6 | Index where queue 2 begins |
| cf1_irq_en | input | 1 | Interrupt enable for queue 1 completion |
| cf1_irq_lvl | input | 5 | Interrupt level for queue 1 completion |
| pf1_set | input | 1 | Queue 1 pause strobe |
| cf2_set | input | 1 | Queue 2 completion strobe |
| pf2_set | input | 1 | Queue 2 pause strobe |
| tor1_set | input | 1 | Queue 1 trigger-overrun strobe |
| tor2_set | input | 1 | Queue 2 trigger-overrun strobe |
| ro_fields | input | 10 | Read-only status fields shown in bits 9:0 |
| rd_en | input | 1 | Status word read strobe |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current status word |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 5 | Level of the pending request |

## Verification
A stale or wrong arm bit shows up on the write that follows. It appears as a flag in `rd_data` that either survives a zero write after a read returned it as one, or drops without such a read, so it is visible in the cycle after that write. A wrong end-of-queue decision shows in bit 15 and in `irq_req` one cycle after the completion strobe. The bench therefore checks `rd_data` after every stimulus, using index, pointer and channel vectors placed on each side of each end condition.

// File: rtl/adc_qstat_pkg.sv
package adc_qstat_pkg;
   localparam int NFLAG   = 6;
   localparam int FLG_CF1 = 0;
   localparam int FLG_PF1 = 1;
   localparam int FLG_CF2 = 2;
   localparam int FLG_PF2 = 3;
   localparam int FLG_TO1 = 4;
   localparam int FLG_TO2 = 5;
endpackage

// File: rtl/adc_qstat_eoq.sv
module adc_qstat_eoq #(
   parameter int IDX_W    = 6,
   parameter int CHAN_W   = 6,
   parameter int EOQ_CODE = 63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [CHAN_W-1:0] chan_i,
   input  logic [IDX_W-1:0]  q2_begin_i,
   output logic              hit_o
);
   localparam logic [IDX_W-1:0]  LAST_IDX = {IDX_W{1'b1}};
   localparam logic [CHAN_W-1:0] EOQ_VAL  = CHAN_W'(EOQ_CODE);

   logic [IDX_W:0] idx_plus;
   logic           below_q2, eoq_code, last_loc;

   always_comb begin
      idx_plus = {1'b0, idx_i} + {{IDX_W{1'b0}}, 1'b1};
      below_q2 = (idx_plus == {1'b0, q2_begin_i});
      eoq_code = (chan_i == EOQ_VAL);
      last_loc = (idx_i == LAST_IDX);
      hit_o    = done_i & (below_q2 | eoq_code | last_loc);
   end

   AST_EOQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> done_i); // R8
endmodule

// File: rtl/adc_qstat_flag.sv
module adc_qstat_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wr_bit_i,
   output logic flag_o
);
   logic flag_q, arm_q, clr, flag_nxt;

   assign clr = wr_i & arm_q & ~wr_bit_i;

   generate
      if (SET_WINS) begin : g_set_wins
         assign flag_nxt = set_i | (flag_q & ~clr);
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> flag_o); // R11
      end else begin : g_clr_wins
         assign flag_nxt = (set_i | flag_q) & ~clr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         flag_q <= flag_nxt;
         arm_q  <= (arm_q & ~wr_i) | (rd_i & flag_q);
      end
   end

   assign flag_o = flag_q;

   AST_NO_CLR_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> $past(wr_i && arm_q && !wr_bit_i)); // R3
endmodule

// File: rtl/adc_qstat_reg.sv
module adc_qstat_reg
   import adc_qstat_pkg::*;
#(
   parameter int IDX_W    = 6,
   parameter int CHAN_W   = 6,
   parameter int EOQ_CODE = 63,
   parameter int LVL_W    = 5,
   parameter int RO_W     = 10,
   parameter bit SET_WINS = 1'b1,
   localparam int REG_W   = NFLAG + RO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q1_cw_done,
   input  logic [IDX_W-1:0]  cw_idx,
   input  logic [CHAN_W-1:0] cw_chan,
   input  logic [IDX_W-1:0]  q2_begin,
   input  logic              cf1_irq_en,
   input  logic [LVL_W-1:0]  cf1_irq_lvl,
   input  logic              pf1_set,
   input  logic              cf2_set,
   input  logic              pf2_set,
   input  logic              tor1_set,
   input  logic              tor2_set,
   input  logic [RO_W-1:0]   ro_fields,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   output logic              irq_req,
   output logic [LVL_W-1:0]  irq_level
);
   initial begin
      if (EOQ_CODE < 0 || EOQ_CODE >= (1 << CHAN_W))
         $error("adc_qstat_reg: EOQ_CODE does not fit CHAN_W");
      if (IDX_W < 1 || LVL_W < 1 || RO_W < 0)
         $error("adc_qstat_reg: bad width parameter");
   end

   logic             q1_end;
   logic [NFLAG-1:0] set_vec, flag_vec;

   adc_qstat_eoq #(.IDX_W(IDX_W), .CHAN_W(CHAN_W), .EOQ_CODE(EOQ_CODE)) u_eoq (
      .clk(clk), .rst_n(rst_n), .done_i(q1_cw_done), .idx_i(cw_idx),
      .chan_i(cw_chan), .q2_begin_i(q2_begin), .hit_o(q1_end));

   always_comb begin
      set_vec          = '0;
      set_vec[FLG_CF1] = q1_end;
      set_vec[FLG_PF1] = pf1_set;
      set_vec[FLG_CF2] = cf2_set;
      set_vec[FLG_PF2] = pf2_set;
      set_vec[FLG_TO1] = tor1_set;
      set_vec[FLG_TO2] = tor2_set;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NFLAG; gi++) begin : g_flag
         adc_qstat_flag #(.SET_WINS(SET_WINS)) u_flag (
            .clk(clk), .rst_n(rst_n), .set_i(set_vec[gi]), .rd_i(rd_en),
            .wr_i(wr_en), .wr_bit_i(wr_data[REG_W-1-gi]), .flag_o(flag_vec[gi]));
         assign rd_data[REG_W-1-gi] = flag_vec[gi];
      end
      if (RO_W > 0) begin : g_ro
         assign rd_data[RO_W-1:0] = ro_fields;
      end
   endgenerate

   assign irq_req   = flag_vec[FLG_CF1] & cf1_irq_en;
   assign irq_level = irq_req ? cf1_irq_lvl : '0;

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (cf1_irq_en && rd_data[REG_W-1])); // R9
   AST_CF1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[REG_W-1] && !(wr_en && !wr_data[REG_W-1])) |=> rd_data[REG_W-1]); // R10
endmodule

// File: tb/sim_adc_qstat_reg.sv
module sim_adc_qstat_reg;
   localparam int CLK_P = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        q1_cw_done = 0, cf1_irq_en = 0;
   logic [5:0]  cw_idx = 0, cw_chan = 0, q2_begin = 0;
   logic [4:0]  cf1_irq_lvl = 5'd0;
   logic        pf1_set = 0, cf2_set = 0, pf2_set = 0, tor1_set = 0, tor2_set = 0;
   logic [9:0]  ro_fields = 10'h2A5;
   logic        rd_en = 0, wr_en = 0;
   logic [15:0] wr_data = 0, rd_data;
   logic        irq_req;
   logic [4:0]  irq_level;
   int checks = 0, errors = 0;
   logic [15:0] rv;

   always #(CLK_P/2) clk = ~clk;

   adc_qstat_reg u0 (.clk(clk), .rst_n(rst_n), .q1_cw_done(q1_cw_done), .cw_idx(cw_idx),
      .cw_chan(cw_chan), .q2_begin(q2_begin), .cf1_irq_en(cf1_irq_en), .cf1_irq_lvl(cf1_irq_lvl),
      .pf1_set(pf1_set), .cf2_set(cf2_set), .pf2_set(pf2_set), .tor1_set(tor1_set),
      .tor2_set(tor2_set), .ro_fields(ro_fields), .rd_en(rd_en), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq_req(irq_req), .irq_level(irq_level));

   // {q2_begin, cw_idx, cw_chan, expected CF1}
   localparam logic [18:0] VEC [8] = '{
      {6'd10, 6'd9,  6'd5,  1'b1},   // R5 just below q2
      {6'd10, 6'd8,  6'd5,  1'b0},   // R8
      {6'd10, 6'd3,  6'd63, 1'b1},   // R6 end code
      {6'd10, 6'd63, 6'd2,  1'b1},   // R7 last location
      {6'd0,  6'd62, 6'd1,  1'b0},   // R5 q2_begin 0 no wrap
      {6'd40, 6'd39, 6'd62, 1'b1},   // R5
      {6'd40, 6'd41, 6'd0,  1'b0},   // R8
      {6'd1,  6'd0,  6'd7,  1'b1}    // R5
   };

   task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_read(output logic [15:0] v);
      @(negedge clk); rd_en = 1; #1 v = rd_data;
      @(negedge clk); rd_en = 0;
   endtask

   task automatic do_write(input logic [15:0] d);
      @(negedge clk); wr_en = 1; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic clear_all();
      logic [15:0] t;
      do_read(t); do_write(16'h0000);
   endtask

   task automatic pulse_done(input logic [5:0] q2, input logic [5:0] idx, input logic [5:0] ch);
      @(negedge clk); q2_begin = q2; cw_idx = idx; cw_chan = ch; q1_cw_done = 1;
      @(negedge clk); q1_cw_done = 0;
   endtask

   initial begin
      #(CLK_P*100000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(rd_data == {6'b0, 10'h2A5}, "R1 reset", rd_data, {6'b0, 10'h2A5});
      rst_n = 1;
      @(negedge clk);
      check(rd_data == 16'h02A5 && irq_req == 0, "R1 after reset", rd_data, 16'h02A5);

      foreach (VEC[i]) begin
         clear_all();
         pulse_done(VEC[i][18:13], VEC[i][12:7], VEC[i][6:1]);
         check(rd_data[15] == VEC[i][0], "R5/R6/R7/R8 end of queue 1",
               16'(rd_data[15]), 16'(VEC[i][0]));
      end
      clear_all();

      // R12 each strobe sets only its own bit
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         pf1_set = (k == 0); cf2_set = (k == 1); pf2_set = (k == 2);
         tor1_set = (k == 3); tor2_set = (k == 4);
         @(negedge clk);
         {pf1_set, cf2_set, pf2_set, tor1_set, tor2_set} = '0;
         check(rd_data[15:10] == 6'(6'b010000 >> k), "R12 strobe sets own flag",
               16'(rd_data[15:10]), 16'(6'b010000 >> k));
         clear_all();
         check(rd_data[15:10] == 6'b0, "R3 read then zero write clears", 16'(rd_data[15:10]), 16'h0);
      end

      // R3 zero write without read
      @(negedge clk); pf1_set = 1; @(negedge clk); pf1_set = 0;
      do_write(16'h0000);
      check(rd_data[14] == 1'b1, "R3 zero write unarmed", rd_data, 16'h4000 | 16'h02A5);

      // R2 read-only bits immune to writes
      do_write(16'h03FF);
      check(rd_data[9:0] == 10'h2A5, "R2 ro after ones write", 16'(rd_data[9:0]), 16'h2A5);
      do_write(16'h0000);
      check(rd_data[9:0] == 10'h2A5, "R2 ro after zero write", 16'(rd_data[9:0]), 16'h2A5);

      // R4 write one consumes arm
      do_read(rv);
      check(rv[14] == 1'b1, "R4 read sees flag", rv, 16'h42A5);
      do_write(16'hFFFF);
      do_write(16'h0000);
      check(rd_data[14] == 1'b1, "R4 arm consumed by write", rd_data, 16'h42A5);

      // selective clear: only PF1 bit zero
      @(negedge clk); tor2_set = 1; @(negedge clk); tor2_set = 0;
      do_read(rv);
      do_write(16'hBFFF);
      check(rd_data[15:10] == 6'b000001, "R3 selective clear", rd_data, 16'h06A5);
      clear_all();

      // R11 set beats clear
      @(negedge clk); tor1_set = 1; @(negedge clk); tor1_set = 0;
      do_read(rv);
      @(negedge clk); wr_en = 1; wr_data = 16'h0000; tor1_set = 1;
      @(negedge clk); wr_en = 0; tor1_set = 0;
      check(rd_data[11] == 1'b1, "R11 set wins", rd_data, 16'h0AA5);
      clear_all();

      // R9 polling without interrupt, then interrupt level
      cf1_irq_lvl = 5'd19;
      pulse_done(6'd20, 6'd63, 6'd0);
      check(rd_data[15] == 1 && irq_req == 0 && irq_level == 0, "R9 flag without irq",
            {irq_req, 10'b0, irq_level}, 16'h0);
      @(negedge clk); cf1_irq_en = 1; #1;
      check(irq_req == 1 && irq_level == 5'd19, "R9 irq asserted",
            {irq_req, 10'b0, irq_level}, {1'b1, 10'b0, 5'd19});

      // R10 sticky against unarmed zero writes and non-ending completions
      do_write(16'h0000);
      pulse_done(6'd20, 6'd5, 6'd3);
      repeat (3) @(negedge clk);
      check(rd_data[15] == 1 && irq_req == 1, "R10 CF1 sticky", rd_data, 16'h82A5);
      clear_all();
      #1;
      check(rd_data[15] == 0 && irq_req == 0 && irq_level == 0, "R9 irq drops on clear",
            {irq_req, 10'b0, irq_level}, 16'h0);

      // R1 reset in the middle
      @(negedge clk); pf2_set = 1; cf2_set = 1; @(negedge clk); pf2_set = 0; cf2_set = 0;
      rst_n = 0; @(negedge clk);
      check(rd_data[15:10] == 0, "R1 mid-run reset", rd_data, 16'h02A5);
      rst_n = 1; @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule